// File: doc/BRIEF.md
# Colour Subcarrier Phase Accumulator

This block is a numerically controlled oscillator that produces the colour subcarrier phase for a composite video encoder. It runs on the 27 MHz pixel clock. On every clock it adds a 32-bit tuning word to a 32-bit phase accumulator that wraps at 2^32. The accumulator's top byte, shifted by a programmable 8-bit phase offset, is the phase output. A sine table downstream turns that phase into a carrier.

The tuning word is written one byte at a time through a small byte-wide register port. Five registers are mapped. Four of them hold the tuning word bytes and one holds the phase offset. The tuning word is worked out as (subcarrier cycles per line / clocks per line) x 2^32, rounded to the nearest integer. For NTSC, 227.5 cycles over 1716 clocks gives 0x21F07C1F. The bytes are held in staging registers. The running word changes only when the most significant byte is written, so the accumulator never uses a word that is only partly updated. Each offset step is 360/256, about 1.41 degrees. A phase-clear input sets the accumulator back to zero.

Top module: `subcarrier_nco`

## Requirements
- R1: After reset the staged tuning bytes are 0x16, 0x7C, 0xF0 and 0x21 (byte 0 to byte 3). The running tuning word is 0x21F07C16, the offset is 0x00, the accumulator is zero, and `phase_out` reads 0.
- R2: The address map is as follows. Addresses 0, 1, 2 and 3 hold tuning word bits 7:0, 15:8, 23:16 and 31:24. Address 4 holds the phase offset. Writes to addresses 5, 6 and 7 change nothing.
- R3: A write to address 0, 1 or 2 updates only its staging byte and leaves the running tuning word unchanged.
- R4: A write to address 3 loads the running word with {written byte, staged byte 2, staged byte 1, staged byte 0}. The add at that same clock edge still uses the old word, and the new word is first added at the following edge.
- R5: On each clock without a clear, the accumulator becomes (accumulator + running word) mod 2^32.
- R6: `phase_out` equals (accumulator bits 31:24 + offset) mod 256, derived directly from registered state.
- R7: When `phase_clear` is high at a clock edge, the accumulator becomes zero at that edge, whatever the tuning word is.
- R8: A write to address 4 sets the offset from the next edge on. It does not disturb the accumulator.
- R9: Writing 0x1F to address 0 and then 0x21 to address 3 after reset sets up the NTSC word 0x21F07C1F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | 27 MHz pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 3 | Register address |
| cfg_wdata | input | 8 | Register write data |
| phase_clear | input | 1 | Sets the accumulator to zero at the next edge |
| phase_out | output | 8 | Subcarrier phase, one LSB per 360/256 degrees |

## Verification
On every cycle, the embedded properties check four things. The accumulator steps by exactly the running word or clears to zero. The running word holds except on a write to the top byte. A top-byte write commits the correct concatenation. The offset follows its own address only.

The exact phase sequence needs the bench's scenarios: the reset defaults, the one-edge delay before a committed word takes effect, wraparound of the accumulator and of the offset sum, and the NTSC word itself. The bench sweeps the offset through all 256 values and runs long stretches with small and all-ones words. It compares every output against an arithmetic model.

// File: rtl/scnco_pkg.sv
package scnco_pkg;
    localparam int unsigned BYTE_W   = 8;
    localparam int unsigned WORD_W   = 32;
    localparam int unsigned CFG_AW   = 3;
    // Power-up tuning word: NTSC pattern with a low byte of 0x16
    localparam logic [WORD_W-1:0] WORD_RST = 32'h21F0_7C16;
endpackage

// File: rtl/scnco_regfile.sv
module scnco_regfile #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned AW     = 3,
    parameter logic [WORD_W-1:0] RST_WORD = 32'h21F0_7C16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [AW-1:0]     cfg_addr,
    input  logic [7:0]        cfg_wdata,
    output logic [WORD_W-1:0] word_q,
    output logic [7:0]        ofs_q
);
    localparam int unsigned NB = WORD_W / 8;
    localparam logic [AW-1:0] TOP_ADDR = AW'(NB - 1);
    localparam logic [AW-1:0] OFS_ADDR = AW'(NB);

    typedef struct packed {
        logic [NB-1:0][7:0] stage;
        logic [WORD_W-1:0]  word;
        logic [7:0]         ofs;
    } rf_t;

    rf_t rf_d, rf_q;
    logic [NB-1:0] byte_hit;

    for (genvar gi = 0; gi < NB; gi++) begin : g_byte_dec
        assign byte_hit[gi] = cfg_we && (cfg_addr == AW'(gi));
    end

    always_comb begin
        rf_d = rf_q;
        for (int i = 0; i < NB; i++) begin
            if (byte_hit[i]) rf_d.stage[i] = cfg_wdata;
        end
        if (byte_hit[NB-1]) rf_d.word = {cfg_wdata, rf_q.stage[NB-2:0]};
        if (cfg_we && cfg_addr == OFS_ADDR) rf_d.ofs = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rf_q <= {RST_WORD, RST_WORD, 8'h00};
        else        rf_q <= rf_d;
    end

    assign word_q = rf_q.word;
    assign ofs_q  = rf_q.ofs;

    // R3: running word holds unless the top byte is written
    p_word_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_addr == TOP_ADDR) |=> $stable(word_q));
    // R4: top-byte write commits written byte over the staged lower bytes
    p_word_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == TOP_ADDR) |=>
            word_q == {$past(cfg_wdata), $past(rf_q.stage[NB-2:0])});
    // R8: offset loads from its own address
    p_ofs_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && cfg_addr == OFS_ADDR) |=> ofs_q == $past(cfg_wdata));
    // R2: offset untouched by any other access
    p_ofs_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_we && cfg_addr == OFS_ADDR) |=> $stable(ofs_q));
endmodule

// File: rtl/scnco_accum.sv
module scnco_accum #(
    parameter int unsigned WORD_W = 32,
    parameter int unsigned OUT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [WORD_W-1:0] word,
    output logic [OUT_W-1:0]  acc_top
);
    typedef struct packed {
        logic [WORD_W-1:0] acc;
    } ac_t;

    ac_t ac_d, ac_q;

    always_comb begin
        ac_d = ac_q;
        if (clr) ac_d.acc = '0;
        else     ac_d.acc = ac_q.acc + word;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ac_q <= '0;
        else        ac_q <= ac_d;
    end

    assign acc_top = ac_q.acc[WORD_W-1 -: OUT_W];

    // R7: clear empties the accumulator at the next edge
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> ac_q.acc == '0);
    // R5: otherwise it advances by exactly the running word
    p_step_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> ac_q.acc == $past(ac_q.acc) + $past(word));
endmodule

// File: rtl/scnco_phase_sum.sv
module scnco_phase_sum #(
    parameter int unsigned OUT_W = 8
) (
    input  logic [OUT_W-1:0] acc_top,
    input  logic [OUT_W-1:0] ofs,
    output logic [OUT_W-1:0] phase
);
    assign phase = acc_top + ofs;
endmodule

// File: rtl/subcarrier_nco.sv
module subcarrier_nco
    import scnco_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [7:0]        cfg_wdata,
    input  logic              phase_clear,
    output logic [7:0]        phase_out
);
    logic [WORD_W-1:0] word_run;
    logic [7:0]        ofs_run;
    logic [7:0]        acc_top;

    scnco_regfile #(.WORD_W(WORD_W), .AW(CFG_AW), .RST_WORD(WORD_RST)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .word_q(word_run), .ofs_q(ofs_run)
    );

    scnco_accum #(.WORD_W(WORD_W), .OUT_W(8)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(phase_clear), .word(word_run),
        .acc_top(acc_top)
    );

    scnco_phase_sum #(.OUT_W(8)) u_sum (
        .acc_top(acc_top), .ofs(ofs_run), .phase(phase_out)
    );
endmodule

// File: tb/test_subcarrier_nco.sv
module test_subcarrier_nco;
    localparam time CLK_PERIOD = 37ns;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_we = 1'b0;
    logic [2:0] cfg_addr = '0;
    logic [7:0] cfg_wdata = '0;
    logic       phase_clear = 1'b0;
    logic [7:0] phase_out;

    int n_vec = 0;
    int n_bad = 0;

    logic [31:0] m_acc, m_word;
    logic [7:0]  m_stage [4];
    logic [7:0]  m_ofs;

    subcarrier_nco i_subcarrier_nco (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .phase_clear(phase_clear), .phase_out(phase_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] m_phase();
        return m_acc[31:24] + m_ofs;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: phase_out=%02h expected %02h", req, act, exp);
        end
    endtask

    // One clock: drive, model the edge, then compare after it
    task automatic step(input logic we, input logic [2:0] a, input logic [7:0] d,
                        input logic clr, input string req);
        cfg_we = we; cfg_addr = a; cfg_wdata = d; phase_clear = clr;
        @(posedge clk);
        m_acc = clr ? 32'h0 : m_acc + m_word;
        if (we && a <= 3'd3) m_stage[a] = d;
        if (we && a == 3'd3) m_word = {d, m_stage[2], m_stage[1], m_stage[0]};
        if (we && a == 3'd4) m_ofs = d;
        @(negedge clk);
        cfg_we = 1'b0; phase_clear = 1'b0;
        check(req, phase_out, m_phase());
    endtask

    task automatic set_word(input logic [31:0] w, input string req);
        for (int b = 0; b < 4; b++) step(1'b1, 3'(b), w[8*b +: 8], 1'b0, req);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: run did not finish, actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        m_acc = 0; m_word = 32'h21F07C16; m_ofs = 0;
        m_stage[0] = 8'h16; m_stage[1] = 8'h7C; m_stage[2] = 8'hF0; m_stage[3] = 8'h21;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset", phase_out, 8'h00);

        // R1: power-up word runs 40 cycles
        for (int i = 0; i < 40; i++) step(1'b0, 3'd0, 8'h00, 1'b0, "R1 default word");
        // R1: committing only the top byte keeps the power-up low byte
        step(1'b1, 3'd3, 8'h21, 1'b0, "R1 top-only commit");
        for (int i = 0; i < 20; i++) step(1'b0, 3'd0, 8'h00, 1'b0, "R1 low byte 0x16");

        // R9: NTSC word from a cleared accumulator, checked arithmetically too
        step(1'b0, 3'd0, 8'h00, 1'b1, "R7 clear");
        step(1'b1, 3'd0, 8'h1F, 1'b0, "R9 low byte");
        step(1'b1, 3'd3, 8'h21, 1'b0, "R9 commit");
        step(1'b0, 3'd0, 8'h00, 1'b1, "R7 clear");
        for (int i = 1; i <= 100; i++) begin
            logic [31:0] e;
            step(1'b0, 3'd0, 8'h00, 1'b0, "R9 ntsc");
            e = 32'(i) * 32'h21F07C1F;
            check("R9 ntsc arith", phase_out, e[31:24]);
        end

        // R2: unmapped addresses change nothing
        for (int a = 5; a < 8; a++) begin
            step(1'b1, 3'(a), 8'hA5, 1'b0, "R2 unmapped");
            step(1'b0, 3'd0, 8'h00, 1'b0, "R2 unmapped after");
        end

        // R8: exhaustive offset sweep with a frozen accumulator
        set_word(32'h0, "R4 load zero");
        step(1'b0, 3'd0, 8'h00, 1'b1, "R7 clear");
        for (int o = 0; o < 256; o++) begin
            step(1'b1, 3'd4, 8'(o), 1'b0, "R8 offset");
            check("R8 offset direct", phase_out, 8'(o));
        end

        // R5/R6: unit step in the top byte, wraps through 256 with offset
        step(1'b1, 3'd4, 8'h80, 1'b0, "R8 offset 80");
        set_word(32'h0100_0000, "R4 unit word");
        for (int i = 0; i < 300; i++) step(1'b0, 3'd0, 8'h00, 1'b0, "R5 R6 unit step");

        // R3: partial writes must not alter the running unit step
        step(1'b1, 3'd0, 8'hFF, 1'b0, "R3 byte0");
        step(1'b1, 3'd1, 8'hFF, 1'b0, "R3 byte1");
        step(1'b1, 3'd2, 8'hFF, 1'b0, "R3 byte2");
        for (int i = 0; i < 16; i++) step(1'b0, 3'd0, 8'h00, 1'b0, "R3 still unit");
        // R4: commit in the same cycle the old word is still added
        step(1'b0, 3'd0, 8'h00, 1'b1, "R7 clear");
        step(1'b1, 3'd3, 8'hFF, 1'b0, "R4 commit edge");
        check("R4 old word on commit edge", phase_out, 8'h81);
        step(1'b0, 3'd0, 8'h00, 1'b0, "R4 new word");
        check("R4 new word next edge", phase_out, 8'h80);
        for (int i = 0; i < 300; i++) step(1'b0, 3'd0, 8'h00, 1'b0, "R5 all-ones wrap");

        // R7: clear with a large word, at several phases
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < k * 3; i++) step(1'b0, 3'd0, 8'h00, 1'b0, "R5 run");
            step(1'b0, 3'd0, 8'h00, 1'b1, "R7 clear");
            check("R7 clear value", phase_out, 8'h80);
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule